// File: doc/BRIEF.md
# Ethernet Link, Speed and Activity Indicator Driver

This block drives the three status lamps of a 10/100 Ethernet physical layer. All three outputs are active low. The link lamp follows a link-up flag. The speed lamp shows whether the port runs at 100 Mb/s. The activity lamp blinks while transmit or receive packets pass through the port.

Packet events reach the block as single-cycle strobes, one per direction. Each strobe comes with a broadcast qualifier and an individual-address-match qualifier. Outside wake-on-LAN mode every strobe counts as activity. In wake-on-LAN mode a configuration bit decides which strobes count: either broadcast or address-match packets, or address-match packets only.

A qualifying strobe starts a blink: the lamp is on for a fixed number of cycles and then off for a fixed number of cycles. Strobes that arrive during a blink are remembered, and they start one more blink as soon as the off time ends. Steady traffic therefore gives a regular flicker, and isolated packets give single flashes.

Top module: `eth_led_ctrl`

## Requirements
- R1: All three lamp outputs are active low. While the synchronous active-high `rst` is held, and in the first cycle after it is released, all three outputs are 1 and the blink timer is idle.
- R2: `link_led_n` equals the inverse of `link_up` as it was at the previous clock edge, whether the speed is 10 or 100 Mb/s.
- R3: `speed_led_n` is 0 one cycle after `speed_100` is 1, and 1 one cycle after `speed_100` is 0.
- R4: When `wol_mode` is 0, any cycle with `tx_evt` or `rx_evt` at 1 qualifies as activity. The broadcast and address-match qualifiers and `wol_uc_only` have no effect.
- R5: When `wol_mode` is 1 and `wol_uc_only` is 0, a strobe qualifies only if its own direction's broadcast qualifier or address-match qualifier is 1.
- R6: When `wol_mode` is 1 and `wol_uc_only` is 1, a strobe qualifies only if its own direction's address-match qualifier is 1. Broadcast-only packets do not light the lamp.
- R7: A qualifying strobe sampled while the timer is idle turns `act_led_n` to 0 from the next cycle for exactly ON_CYC cycles. The lamp then stays at 1 for OFF_CYC cycles.
- R8: Qualifying strobes sampled during the on or off time of a blink are latched. They start the next blink in the cycle right after the off time ends. Any number of strobes within one blink produces only one further blink.
- R9: If no strobe was latched by the end of the off time, the timer returns to idle and `act_led_n` stays at 1 until a new qualifying strobe arrives.
- R10: Transmit and receive strobes each light the activity lamp on their own, each judged by its own direction's qualifiers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| link_up | input | 1 | Link present flag |
| speed_100 | input | 1 | 1 = 100 Mb/s, 0 = 10 Mb/s |
| tx_evt | input | 1 | Single-cycle strobe, one transmitted packet |
| tx_bcast | input | 1 | Transmitted packet is broadcast |
| tx_uc_match | input | 1 | Transmitted packet matched the individual address |
| rx_evt | input | 1 | Single-cycle strobe, one received packet |
| rx_bcast | input | 1 | Received packet is broadcast |
| rx_uc_match | input | 1 | Received packet matched the individual address |
| wol_mode | input | 1 | Wake-on-LAN mode active |
| wol_uc_only | input | 1 | In wake-on-LAN mode, count only address-match packets |
| link_led_n | output | 1 | Link lamp, active low |
| act_led_n | output | 1 | Activity lamp, active low |
| speed_led_n | output | 1 | Speed lamp, active low |

## Verification
The assertions assume that each qualifier is meaningful only in a cycle where its own strobe is high. They also assume that the mode flag and the configuration bit change only between packets. The bench drives every qualifier combination in a single cycle together with its strobe, and it clears all of them in the next cycle. The on-length and off-gap checks count cycles from the lamp output itself. They therefore assume that a reset in the middle of a blink may cut the blink short. The bench applies such a reset only once, in the phase that checks the reset state.

// File: rtl/led_pkg.sv
`timescale 1ns/1ps
package led_pkg;

  typedef enum logic [1:0] {
    BLK_IDLE = 2'd0,
    BLK_ON   = 2'd1,
    BLK_OFF  = 2'd2
  } blink_st_t;

  // Decide whether one packet strobe counts as lamp activity.
  function automatic logic pkt_counts(input logic evt, input logic bc,
                                      input logic uc, input logic wol,
                                      input logic uc_only);
    if (!evt)    return 1'b0;
    if (!wol)    return 1'b1;
    if (uc_only) return uc;
    return bc | uc;
  endfunction

  // Counter width able to hold the larger of two cycle counts.
  function automatic int unsigned cnt_width(input int unsigned a,
                                            input int unsigned b);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m < 2) ? 1 : $clog2(m);
  endfunction

endpackage

// File: rtl/led_act_qual.sv
`timescale 1ns/1ps
module led_act_qual #(
  parameter int unsigned NDIR = 2
) (
  input  logic [NDIR-1:0] evt,
  input  logic [NDIR-1:0] bc,
  input  logic [NDIR-1:0] uc,
  input  logic            wol_mode,
  input  logic            wol_uc_only,
  output logic [NDIR-1:0] dir_hit,
  output logic            any_hit
);
  import led_pkg::*;

  genvar d;
  generate
    for (d = 0; d < NDIR; d++) begin : g_dir
      assign dir_hit[d] = pkt_counts(evt[d], bc[d], uc[d], wol_mode, wol_uc_only);
    end
  endgenerate

  assign any_hit = |dir_hit;
endmodule

// File: rtl/led_blink_timer.sv
`timescale 1ns/1ps
module led_blink_timer #(
  parameter int unsigned ON_CYC  = 3750000,
  parameter int unsigned OFF_CYC = 3750000
) (
  input  logic clk,
  input  logic rst,
  input  logic trig,
  output logic lamp_on,
  output logic idle,
  output logic pend
);
  import led_pkg::*;

  localparam int unsigned CW = cnt_width(ON_CYC, OFF_CYC);
  localparam logic [CW-1:0] ON_LOAD  = CW'(ON_CYC - 1);
  localparam logic [CW-1:0] OFF_LOAD = CW'(OFF_CYC - 1);

  blink_st_t     st;
  logic [CW-1:0] cnt;
  logic          at_end;

  assign at_end = (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= BLK_IDLE;
      cnt  <= '0;
      pend <= 1'b0;
    end else begin
      case (st)
        BLK_IDLE: begin
          if (trig) begin
            st  <= BLK_ON;
            cnt <= ON_LOAD;
          end
        end
        BLK_ON: begin
          if (trig) pend <= 1'b1;
          if (at_end) begin
            st  <= BLK_OFF;
            cnt <= OFF_LOAD;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        BLK_OFF: begin
          if (at_end) begin
            pend <= 1'b0;
            if (pend || trig) begin
              st  <= BLK_ON;
              cnt <= ON_LOAD;
            end else begin
              st  <= BLK_IDLE;
            end
          end else begin
            cnt <= cnt - 1'b1;
            if (trig) pend <= 1'b1;
          end
        end
        default: begin
          st   <= BLK_IDLE;
          cnt  <= '0;
          pend <= 1'b0;
        end
      endcase
    end
  end

  assign lamp_on = (st == BLK_ON);
  assign idle    = (st == BLK_IDLE);
endmodule

// File: rtl/led_level_drv.sv
`timescale 1ns/1ps
module led_level_drv #(
  parameter int unsigned W = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] lvl,
  output logic [W-1:0] lamp_n
);
  genvar i;
  generate
    for (i = 0; i < W; i++) begin : g_bit
      always_ff @(posedge clk) begin
        if (rst) lamp_n[i] <= 1'b1;
        else     lamp_n[i] <= ~lvl[i];
      end
    end
  endgenerate
endmodule

// File: rtl/eth_led_ctrl.sv
`timescale 1ns/1ps
module eth_led_ctrl #(
  parameter int unsigned ON_CYC  = 3750000,
  parameter int unsigned OFF_CYC = 3750000
) (
  input  logic clk,
  input  logic rst,
  input  logic link_up,
  input  logic speed_100,
  input  logic tx_evt,
  input  logic tx_bcast,
  input  logic tx_uc_match,
  input  logic rx_evt,
  input  logic rx_bcast,
  input  logic rx_uc_match,
  input  logic wol_mode,
  input  logic wol_uc_only,
  output logic link_led_n,
  output logic act_led_n,
  output logic speed_led_n
);
  localparam int unsigned NDIR = 2;
  localparam int unsigned NLVL = 2;

  logic [NDIR-1:0] dir_hit;
  logic            qual_hit;
  logic            blink_on;
  logic            blink_idle;
  logic            blink_pend;
  logic [NLVL-1:0] lvl_n;

  led_act_qual #(.NDIR(NDIR)) u_qual (
    .evt         ({rx_evt, tx_evt}),
    .bc          ({rx_bcast, tx_bcast}),
    .uc          ({rx_uc_match, tx_uc_match}),
    .wol_mode    (wol_mode),
    .wol_uc_only (wol_uc_only),
    .dir_hit     (dir_hit),
    .any_hit     (qual_hit)
  );

  led_blink_timer #(.ON_CYC(ON_CYC), .OFF_CYC(OFF_CYC)) u_blink (
    .clk     (clk),
    .rst     (rst),
    .trig    (qual_hit),
    .lamp_on (blink_on),
    .idle    (blink_idle),
    .pend    (blink_pend)
  );

  led_level_drv #(.W(NLVL)) u_lvl (
    .clk    (clk),
    .rst    (rst),
    .lvl    ({speed_100, link_up}),
    .lamp_n (lvl_n)
  );

  assign link_led_n  = lvl_n[0];
  assign speed_led_n = lvl_n[1];
  assign act_led_n   = ~blink_on;
endmodule

// File: rtl/led_chk.sv
`timescale 1ns/1ps
module led_chk #(
  parameter int unsigned ON_CYC  = 3750000,
  parameter int unsigned OFF_CYC = 3750000
) (
  input logic clk,
  input logic rst,
  input logic link_up,
  input logic speed_100,
  input logic tx_evt,
  input logic rx_evt,
  input logic tx_uc_match,
  input logic rx_uc_match,
  input logic wol_mode,
  input logic wol_uc_only,
  input logic qual_hit,
  input logic blink_idle,
  input logic link_led_n,
  input logic act_led_n,
  input logic speed_led_n
);
  logic        seen_rst, armed, was_on;
  logic [31:0] on_run, off_run;

  always_ff @(posedge clk) begin
    if (rst) begin
      seen_rst <= 1'b1;
      armed    <= 1'b0;
      was_on   <= 1'b0;
      on_run   <= '0;
      off_run  <= '0;
    end else begin
      armed <= seen_rst;
      if (!act_led_n) begin
        was_on  <= 1'b1;
        on_run  <= on_run + 1;
        off_run <= '0;
      end else begin
        on_run  <= '0;
        if (off_run != 32'hFFFF_FFFF) off_run <= off_run + 1;
      end
    end
  end

  p_link_follow_r2: assert property (@(posedge clk) disable iff (rst)
    armed |-> (link_led_n == !$past(link_up)));

  p_speed_follow_r3: assert property (@(posedge clk) disable iff (rst)
    armed |-> (speed_led_n == !$past(speed_100)));

  p_plain_counts_r4: assert property (@(posedge clk) disable iff (rst)
    (!wol_mode && (tx_evt || rx_evt)) |-> qual_hit);

  p_uc_only_r6: assert property (@(posedge clk) disable iff (rst)
    (wol_mode && wol_uc_only && !tx_uc_match && !rx_uc_match) |-> !qual_hit);

  p_start_blink_r7: assert property (@(posedge clk) disable iff (rst)
    (qual_hit && blink_idle) |=> !act_led_n);

  p_on_len_r7: assert property (@(posedge clk) disable iff (rst)
    !act_led_n |-> (on_run < ON_CYC));

  p_off_gap_r8: assert property (@(posedge clk) disable iff (rst)
    (was_on && $fell(act_led_n)) |-> (off_run >= OFF_CYC));

  p_idle_dark_r9: assert property (@(posedge clk) disable iff (rst)
    blink_idle |-> act_led_n);
endmodule

bind eth_led_ctrl led_chk #(.ON_CYC(ON_CYC), .OFF_CYC(OFF_CYC)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .link_up     (link_up),
  .speed_100   (speed_100),
  .tx_evt      (tx_evt),
  .rx_evt      (rx_evt),
  .tx_uc_match (tx_uc_match),
  .rx_uc_match (rx_uc_match),
  .wol_mode    (wol_mode),
  .wol_uc_only (wol_uc_only),
  .qual_hit    (qual_hit),
  .blink_idle  (blink_idle),
  .link_led_n  (link_led_n),
  .act_led_n   (act_led_n),
  .speed_led_n (speed_led_n)
);

// File: tb/tb_eth_led_ctrl.sv
`timescale 1ns/1ps
module tb_eth_led_ctrl;
  localparam int ON  = 3;
  localparam int OFF = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic link_up = 0, speed_100 = 0;
  logic tx_evt = 0, tx_bcast = 0, tx_uc_match = 0;
  logic rx_evt = 0, rx_bcast = 0, rx_uc_match = 0;
  logic wol_mode = 0, wol_uc_only = 0;
  logic link_led_n, act_led_n, speed_led_n;

  int total = 0;
  int bad = 0;
  bit fin = 0;
  string act_tag = "R7";

  always #4 clk = ~clk;

  eth_led_ctrl #(.ON_CYC(ON), .OFF_CYC(OFF)) dut (
    .clk(clk), .rst(rst), .link_up(link_up), .speed_100(speed_100),
    .tx_evt(tx_evt), .tx_bcast(tx_bcast), .tx_uc_match(tx_uc_match),
    .rx_evt(rx_evt), .rx_bcast(rx_bcast), .rx_uc_match(rx_uc_match),
    .wol_mode(wol_mode), .wol_uc_only(wol_uc_only),
    .link_led_n(link_led_n), .act_led_n(act_led_n), .speed_led_n(speed_led_n));

  task automatic chk(input string req, input logic got, input logic exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got=%0b exp=%0b at %0t", req, got, exp, $time);
    end
  endtask

  // Qualification per direction, written as a mask of accepted qualifiers.
  function automatic bit dir_ok(bit e, bit b, bit u, bit w, bit c);
    bit [1:0] need;
    need = w ? (c ? 2'b10 : 2'b11) : 2'b00;
    return e && ((need == 2'b00) || ((need & {u, b}) != 2'b00));
  endfunction

  // Cycle model: ph counts edges since the current blink began.
  bit busy = 0, pend = 0;
  int ph = 0;
  bit exp_act_n = 1, exp_link_n = 1, exp_spd_n = 1;

  always @(posedge clk) begin
    bit h;
    h = dir_ok(tx_evt, tx_bcast, tx_uc_match, wol_mode, wol_uc_only) ||
        dir_ok(rx_evt, rx_bcast, rx_uc_match, wol_mode, wol_uc_only);
    if (rst) begin
      busy = 0; pend = 0; ph = 0;
      exp_link_n = 1; exp_spd_n = 1;
    end else begin
      exp_link_n = !link_up;
      exp_spd_n  = !speed_100;
      if (!busy) begin
        if (h) begin busy = 1; ph = 0; end
      end else begin
        ph = ph + 1;
        if (ph == ON + OFF) begin
          if (pend || h) begin ph = 0; pend = 0; end
          else begin busy = 0; pend = 0; end
        end else if (h) pend = 1;
      end
    end
    exp_act_n = !(busy && ph < ON);
    #1;
    if (!fin) begin
      chk(act_tag, act_led_n, exp_act_n);
      chk("R2", link_led_n, exp_link_n);
      chk("R3", speed_led_n, exp_spd_n);
    end
  end

  task automatic clear_evt();
    tx_evt = 0; tx_bcast = 0; tx_uc_match = 0;
    rx_evt = 0; rx_bcast = 0; rx_uc_match = 0;
  endtask

  task automatic idle_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #(8 * 200000);
    if (!fin) begin
      fin = 1;
      total++; bad++;
      $display("FAIL watchdog: got=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    idle_n(3);
    chk("R1", link_led_n, 1'b1);
    chk("R1", act_led_n, 1'b1);
    chk("R1", speed_led_n, 1'b1);
    rst = 0;
    @(negedge clk);
    chk("R1", act_led_n, 1'b1);

    // R4 R5 R6 R10: every strobe/qualifier/mode combination
    for (int c = 0; c < 256; c++) begin
      bit q;
      string tag;
      tx_evt = c[0]; rx_evt = c[1]; tx_bcast = c[2]; tx_uc_match = c[3];
      rx_bcast = c[4]; rx_uc_match = c[5]; wol_mode = c[6]; wol_uc_only = c[7];
      q = dir_ok(c[0], c[2], c[3], c[6], c[7]) || dir_ok(c[1], c[4], c[5], c[6], c[7]);
      tag = !c[6] ? "R4" : (c[7] ? "R6" : "R5");
      act_tag = tag;
      @(negedge clk);
      clear_evt();
      chk(tag, act_led_n, !q);
      if (c[0] != c[1] && !c[6]) chk("R10", act_led_n, 1'b0);
      idle_n(ON + OFF + 1);
      chk("R9", act_led_n, 1'b1);
    end
    wol_mode = 0; wol_uc_only = 0;

    // R8: continuous transmit traffic, then one strobe inside a blink
    act_tag = "R8";
    tx_evt = 1;
    idle_n(3 * (ON + OFF));
    clear_evt();
    idle_n(2 * (ON + OFF));
    rx_evt = 1; @(negedge clk); clear_evt();
    idle_n(1);
    rx_evt = 1; @(negedge clk); clear_evt();
    rx_evt = 1; @(negedge clk); clear_evt();
    idle_n(ON + OFF - 2);
    chk("R8", act_led_n, 1'b0);
    idle_n(ON + OFF + 1);
    chk("R9", act_led_n, 1'b1);

    // R7: single strobe, exact on length
    act_tag = "R7";
    tx_evt = 1; @(negedge clk); clear_evt();
    for (int i = 0; i < ON; i++) begin
      chk("R7", act_led_n, 1'b0);
      @(negedge clk);
    end
    chk("R7", act_led_n, 1'b1);
    idle_n(OFF + 2);

    // R2 R3: level lamps under every link/speed pair
    for (int k = 0; k < 4; k++) begin
      link_up = k[0]; speed_100 = k[1];
      @(negedge clk);
      chk("R2", link_led_n, !k[0]);
      chk("R3", speed_led_n, !k[1]);
    end

    // R1: reset in the middle of a blink
    act_tag = "R1";
    rx_evt = 1; @(negedge clk); clear_evt();
    rst = 1; @(negedge clk);
    chk("R1", act_led_n, 1'b1);
    chk("R1", link_led_n, 1'b1);
    chk("R1", speed_led_n, 1'b1);
    rst = 0; @(negedge clk);
    chk("R1", act_led_n, 1'b1);
    idle_n(2);

    fin = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule